// File: doc/BRIEF.md
# Filter capacitor calibration controller

This block tunes the two capacitor banks of an on-chip continuous-time filter so that the filter's corner tracks the reference clock. The host writes a target-response code. That write starts a tuning run. During the run the block counts rising edges of a free-running internal RC oscillator over a fixed window of reference-clock cycles. It multiplies that count by the target code and scales the result down, and then adds a separate offset for each bank. The result is clipped to the range a bank can realise, which is 0 to 36 unit elements. The block then drives the two bank codes.

Each bank has an error flag. The flag is raised when that bank's code had to be clipped, which means the requested response cannot be met. A busy flag covers each run, and a one-cycle done pulse closes it. A target of 0x60 is the usual operating point, giving a corner near the reference clock divided by 3.2.

Writing zero to the target register starts no run. Instead it locks the register, so that every later write is ignored until the next reset.

Top module: `filter_cap_cal`

## Requirements
- R1: After reset, busy, done, both bank codes and both error flags are all 0.
- R2: A write with nonzero data while the register is unlocked starts a run. busy is high for WIN_CYCLES+1 cycles. In the first cycle after busy falls, done is high for exactly one cycle, and the new codes and flags appear in that same cycle.
- R3: During the window, each rising edge of osc_in is counted. osc_in first passes through a two-flop synchronizer. The count is cleared at the start of each run.
- R4: Each bank code is floor(count × target / 2^SHIFT) plus that bank's offset parameter: OFS_A for bank A and OFS_B for bank B.
- R5: When a bank's raw value is above 36, its code is 36 and its error flag is 1.
- R6: When a bank's raw value is below 0, its code is 0 and its error flag is 1.
- R7: When a bank's raw value lies in 0..36, that value is the code and the error flag is 0. This includes exactly 36.
- R8: A write of 0x00 starts no run, and busy stays 0. After it, writes are ignored, so no run starts and the codes are unchanged, until reset. A reset clears the lock.
- R9: A nonzero write while busy restarts the run. The window and the count start over, and only one done pulse follows.
- R10: The bank codes and error flags hold their values between runs. Each run rewrites them, so a flag set by an earlier run clears when the new value is in range.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset; also clears the lock |
| wr_en | input | 1 | Target register write strobe |
| wr_data | input | TGT_W | Target-response code being written |
| osc_in | input | 1 | Internal RC oscillator output, asynchronous to clk |
| busy | output | 1 | High while a tuning run is in progress |
| done | output | 1 | One-cycle pulse at the end of a run |
| code_a | output | 6 | Capacitor code for bank A (0..36) |
| code_b | output | 6 | Capacitor code for bank B (0..36) |
| err_a | output | 1 | Bank A code was clipped in the last run |
| err_b | output | 1 | Bank B code was clipped in the last run |

## Verification
The assertions assume that a new run is never requested during the single calculation cycle at the end of the window. They also assume that osc_in pulses are each at least one reference cycle high and one cycle low, so that no edge is lost in the synchronizer. The stimulus drives osc_in on the falling clock edge with pulses one cycle high and one cycle low. Pulses begin only a few cycles after a run starts and end well before its window closes, so the expected count equals exactly the number of pulses sent. Restart writes are issued only in the middle of a window.

// File: rtl/fcal_pkg.sv
package fcal_pkg;

    localparam int CODE_MAX = 36;
    localparam int CODE_W   = 6;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_MEAS = 2'd1,
        ST_CALC = 2'd2
    } cal_state_e;

    typedef struct packed {
        logic [CODE_W-1:0] code;
        logic              err;
    } bank_res_t;

    // Clip a signed raw bank value into the realisable range.
    function automatic bank_res_t sat_code(input logic signed [31:0] raw);
        bank_res_t r;
        if (raw < 0) begin
            r.code = '0;
            r.err  = 1'b1;
        end else if (raw > CODE_MAX) begin
            r.code = CODE_W'(CODE_MAX);
            r.err  = 1'b1;
        end else begin
            r.code = raw[CODE_W-1:0];
            r.err  = 1'b0;
        end
        return r;
    endfunction

endpackage

// File: rtl/osc_edge_counter.sv
module osc_edge_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             osc_in,
    input  logic             clear,
    input  logic             enable,
    output logic [CNT_W-1:0] count
);
    logic [2:0] sync_q;
    logic       rise;

    always_ff @(posedge clk) begin
        if (rst) sync_q <= '0;
        else     sync_q <= {sync_q[1:0], osc_in};
    end

    assign rise = sync_q[1] & ~sync_q[2];

    always_ff @(posedge clk) begin
        if (rst || clear)
            count <= '0;
        else if (enable && rise && (count != {CNT_W{1'b1}}))
            count <= count + 1'b1;
    end
endmodule

// File: rtl/cal_sequencer.sv
module cal_sequencer
    import fcal_pkg::*;
#(
    parameter int WIN_CYCLES = 1024
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    output cal_state_e state,
    output logic       done
);
    localparam int WIN_W = (WIN_CYCLES > 1) ? $clog2(WIN_CYCLES) : 1;
    localparam logic [WIN_W-1:0] WIN_LAST = WIN_W'(WIN_CYCLES - 1);

    logic [WIN_W-1:0] win_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            win_q <= '0;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start) begin
                state <= ST_MEAS;
                win_q <= '0;
            end else begin
                case (state)
                    ST_MEAS: begin
                        if (win_q == WIN_LAST) state <= ST_CALC;
                        else                   win_q <= win_q + 1'b1;
                    end
                    ST_CALC: begin
                        state <= ST_IDLE;
                        done  <= 1'b1;
                    end
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end
endmodule

// File: rtl/bank_code_unit.sv
module bank_code_unit
    import fcal_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int TGT_W  = 8,
    parameter int SHIFT  = 12,
    parameter int OFFSET = 0
) (
    input  logic [CNT_W-1:0] count,
    input  logic [TGT_W-1:0] target,
    output bank_res_t        result
);
    localparam int PROD_W = CNT_W + TGT_W;

    logic [PROD_W-1:0]  prod;
    logic signed [31:0] raw;

    always_comb begin
        prod   = PROD_W'(count) * PROD_W'(target);
        raw    = signed'(32'(prod >> SHIFT)) + 32'(OFFSET);
        result = sat_code(raw);
    end
endmodule

// File: rtl/filter_cap_cal.sv
module filter_cap_cal
    import fcal_pkg::*;
#(
    parameter int WIN_CYCLES = 1024,
    parameter int CNT_W      = 16,
    parameter int TGT_W      = 8,
    parameter int SHIFT      = 12,
    parameter int OFS_A      = 0,
    parameter int OFS_B      = 0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [TGT_W-1:0]  wr_data,
    input  logic              osc_in,
    output logic              busy,
    output logic              done,
    output logic [CODE_W-1:0] code_a,
    output logic [CODE_W-1:0] code_b,
    output logic              err_a,
    output logic              err_b
);
    localparam int NBANK = 2;

    logic             lock_q;
    logic [TGT_W-1:0] target_q;
    logic             accept;
    logic             start;
    cal_state_e       state;
    logic [CNT_W-1:0] count;
    bank_res_t        res_d [NBANK];
    bank_res_t        res_q [NBANK];

    assign accept = wr_en && !lock_q;
    assign start  = accept && (wr_data != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            lock_q   <= 1'b0;
            target_q <= '0;
        end else if (accept) begin
            if (wr_data == '0) lock_q   <= 1'b1;
            else               target_q <= wr_data;
        end
    end

    osc_edge_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk    (clk),
        .rst    (rst),
        .osc_in (osc_in),
        .clear  (start),
        .enable (state == ST_MEAS),
        .count  (count)
    );

    cal_sequencer #(.WIN_CYCLES(WIN_CYCLES)) u_seq (
        .clk   (clk),
        .rst   (rst),
        .start (start),
        .state (state),
        .done  (done)
    );

    for (genvar g = 0; g < NBANK; g++) begin : g_bank
        localparam int OFS = (g == 0) ? OFS_A : OFS_B;

        bank_code_unit #(
            .CNT_W(CNT_W), .TGT_W(TGT_W), .SHIFT(SHIFT), .OFFSET(OFS)
        ) u_bank (
            .count  (count),
            .target (target_q),
            .result (res_d[g])
        );

        always_ff @(posedge clk) begin
            if (rst)                                 res_q[g] <= '0;
            else if (state == ST_CALC && !start)     res_q[g] <= res_d[g];
        end
    end

    assign busy   = (state != ST_IDLE);
    assign code_a = res_q[0].code;
    assign err_a  = res_q[0].err;
    assign code_b = res_q[1].code;
    assign err_b  = res_q[1].err;
endmodule

// File: rtl/fcal_checker.sv
module fcal_checker
    import fcal_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              busy,
    input logic              done,
    input logic [CODE_W-1:0] code_a,
    input logic [CODE_W-1:0] code_b,
    input logic              err_a,
    input logic              err_b,
    input logic              locked
);
    a_r2_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    a_r2_done_after_busy: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> done);

    a_r5_code_a_range: assert property (@(posedge clk) disable iff (rst)
        code_a <= CODE_W'(CODE_MAX));

    a_r5_code_b_range: assert property (@(posedge clk) disable iff (rst)
        code_b <= CODE_W'(CODE_MAX));

    a_r6_err_a_at_limit: assert property (@(posedge clk) disable iff (rst)
        err_a |-> (code_a == '0 || code_a == CODE_W'(CODE_MAX)));

    a_r6_err_b_at_limit: assert property (@(posedge clk) disable iff (rst)
        err_b |-> (code_b == '0 || code_b == CODE_W'(CODE_MAX)));

    a_r8_lock_sticky: assert property (@(posedge clk) disable iff (rst)
        locked |=> locked);

    a_r8_no_run_when_locked: assert property (@(posedge clk) disable iff (rst)
        (locked && !busy) |=> !busy);

    a_r10_hold_a: assert property (@(posedge clk) disable iff (rst)
        !$stable({code_a, err_a}) |-> done);

    a_r10_hold_b: assert property (@(posedge clk) disable iff (rst)
        !$stable({code_b, err_b}) |-> done);
endmodule

bind filter_cap_cal fcal_checker u_chk (
    .clk    (clk),
    .rst    (rst),
    .busy   (busy),
    .done   (done),
    .code_a (code_a),
    .code_b (code_b),
    .err_a  (err_a),
    .err_b  (err_b),
    .locked (lock_q)
);

// File: tb/filter_cap_cal_test.sv
module filter_cap_cal_test;
    localparam int CLK_PERIOD = 10;
    localparam int WIN        = 4096;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic       osc_in = 1'b0;
    logic       busy, done, err_a, err_b;
    logic [5:0] code_a, code_b;

    typedef struct {
        logic [5:0] a;
        logic       ea;
        logic [5:0] b;
        logic       eb;
        string      tag;
    } exp_t;

    exp_t sb[$];
    int   n_chk = 0;
    int   n_bad = 0;

    filter_cap_cal #(.WIN_CYCLES(WIN), .OFS_A(0), .OFS_B(-3)) uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .osc_in(osc_in),
        .busy(busy), .done(done), .code_a(code_a), .code_b(code_b),
        .err_a(err_a), .err_b(err_b)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Monitor: pop and compare each finished run.
    always @(negedge clk) begin
        if (!rst && done) begin
            if (sb.size() == 0) begin
                check("R9 unexpected done", 1, 0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                check({e.tag, " code_a"}, code_a, e.a);
                check({e.tag, " err_a"},  err_a,  e.ea);
                check({e.tag, " code_b"}, code_b, e.b);
                check({e.tag, " err_b"},  err_b,  e.eb);
            end
        end
    end

    task automatic do_write(input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic pulses(input int n);
        for (int i = 0; i < n; i++) begin
            osc_in = 1'b1;
            @(negedge clk);
            osc_in = 1'b0;
            @(negedge clk);
        end
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic run_case(input string tag, input logic [7:0] t, input int n,
                            input int a, input int ea, input int b, input int eb);
        exp_t e;
        e.a = 6'(a); e.ea = ea[0]; e.b = 6'(b); e.eb = eb[0]; e.tag = tag;
        sb.push_back(e);
        do_write(t);
        @(negedge clk);
        pulses(n);
        wait_idle();
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        int bcnt;
        logic [5:0] ha, hb;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check("R1 busy", busy, 0);
        check("R1 done", done, 0);
        check("R1 code_a", code_a, 0);
        check("R1 code_b", code_b, 0);
        check("R1 errs", {err_a, err_b}, 0);

        // R2 busy length and done position, R3/R4 count and arithmetic
        begin
            exp_t e;
            e.a = 7; e.ea = 0; e.b = 4; e.eb = 0; e.tag = "R4 nominal";
            sb.push_back(e);
            @(negedge clk);
            wr_en = 1'b1; wr_data = 8'h60;
            @(negedge clk);
            wr_en = 1'b0;
            bcnt = 0;
            fork
                pulses(300);
                begin
                    while (busy) begin bcnt++; @(negedge clk); end
                end
            join
            check("R2 busy cycles", bcnt, WIN + 1);
            check("R2 done at busy fall", done, 1);
            @(negedge clk);
            check("R2 done one cycle", done, 0);
        end

        // R10 hold between runs
        repeat (50) @(negedge clk);
        check("R10 hold code_a", code_a, 7);
        check("R10 hold code_b", code_b, 4);

        // R5 high clamp on both banks: 1500*255>>12 = 93
        run_case("R5 high clamp", 8'hFF, 1500, 36, 1, 36, 1);
        // R6 low clamp on bank B: 10*1>>12 = 0, B = -3
        run_case("R6 low clamp", 8'h01, 10, 0, 0, 0, 1);
        // R7 exactly 36: 1536*96>>12 = 36, B = 33
        run_case("R7 edge 36", 8'h60, 1536, 36, 0, 33, 0);
        // R5 just above: 1579*96>>12 = 37, B = 34
        run_case("R5 edge 37", 8'h60, 1579, 36, 1, 34, 0);
        // R10 flags clear on an in-range run; R3 count cleared per run
        run_case("R10 err clear", 8'h60, 300, 7, 0, 4, 0);

        // R9 restart during busy: only the second window counts
        begin
            exp_t e;
            e.a = 7; e.ea = 0; e.b = 4; e.eb = 0; e.tag = "R9 restart";
            sb.push_back(e);
            do_write(8'h60);
            @(negedge clk);
            pulses(100);
            do_write(8'h60);
            @(negedge clk);
            pulses(300);
            wait_idle();
            repeat (5) @(negedge clk);
            check("R9 queue drained", sb.size(), 0);
        end

        // R8 zero write locks
        ha = code_a; hb = code_b;
        do_write(8'h00);
        check("R8 zero write no run", busy, 0);
        do_write(8'h60);
        bcnt = 0;
        for (int i = 0; i < 20; i++) begin
            if (busy) bcnt++;
            @(negedge clk);
        end
        check("R8 locked write ignored", bcnt, 0);
        check("R8 code_a unchanged", code_a, ha);
        check("R8 code_b unchanged", code_b, hb);

        // R8 reset clears lock
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        check("R1 reset after lock", code_a, 0);
        run_case("R8 unlocked after reset", 8'h60, 400, 9, 0, 6, 0);
        repeat (5) @(negedge clk);
        check("R2 all runs reported", sb.size(), 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule